// File: doc/BRIEF.md
# Receive Character Queue with Level-Based Flow Control

This block sits between the receive shifter of a serial port and the bus-side read port. Each received 8-bit character is appended to a circular queue. The bus side drains the queue in one of two ways. A byte access takes one character. A word access can take four characters at once, with the oldest character in the lowest byte.

The block reports the current fill level, and it reports empty, full and the two threshold conditions as live flags. Two sticky error flags record a short word read and a dropped character. A ready request, whose granularity software chooses, tells the bus or a DMA engine that enough characters are waiting.

When the FIFO is enabled, the handshake mode is selected and flow-control steering is enabled, the request-to-send output follows the fill level with hysteresis. It rises once the level reaches the upper threshold and falls once the level drains to the lower threshold.

Top module: `rxq_flow_top`

## Requirements
- R1: A byte read (`rd_req`=1, `rd_word`=0) of a non-empty queue pops exactly the oldest character and returns it in `rd_data[7:0]`, with `rd_data[31:8]` zero.
- R2: In multi-character mode (`cfg_fifo_en`=1 and `cfg_nine_bit`=0), a word read (`rd_word`=1) with at least four characters stored pops four characters. The oldest is returned in bits 7:0, the next in 15:8, then 23:16, and the newest in 31:24.
- R3: A word read in multi-character mode with fewer than four characters stored, or any read of an empty queue, pops nothing and returns zero. It also sets the sticky `ptr_err` flag.
- R4: In single-character mode (`cfg_nine_bit`=1 or `cfg_fifo_en`=0), a word read behaves exactly like a byte read.
- R5: A write (`wr_valid`=1) while `level` equals DEPTH is dropped and sets the sticky `overrun` flag. `level` never exceeds DEPTH.
- R6: `level` (6 bits) counts the stored characters. `empty` is high when `level` is 0. `full` is high when `level` equals DEPTH. `thr_hi_hit` is high when `level` ≥ `cfg_thr_hi`. `thr_lo_hit` is high when `level` ≤ `cfg_thr_lo`.
- R7: `rx_ready` depends on the 2-bit `cfg_rdy_gran`. Code 0 needs `level` ≥ 1, code 1 needs `level` ≥ 2, code 2 needs `level` ≥ 4, and code 3 is treated as code 0.
- R8: While `cfg_fifo_en`, `cfg_hs_mode` and `cfg_rts_en` are all 1, `rts` is registered from the post-update level. It goes to 1 when that level is ≥ `cfg_thr_hi`, goes to 0 when it is ≤ `cfg_thr_lo`, and holds in between. Otherwise `rts` is 0. Valid settings satisfy 0 < `cfg_thr_lo` < `cfg_thr_hi` ≤ DEPTH.
- R9: A `clr` pulse empties the queue, brings `level` to 0, clears `ptr_err` and `overrun`, and drives `rts` low. It overrides any write or read in the same cycle.
- R10: A write and a read in the same cycle both take effect, so the level changes by one minus the number popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fifo_en | input | 1 | FIFO operation enable |
| cfg_hs_mode | input | 1 | Hardware handshake mode selected |
| cfg_rts_en | input | 1 | Level-driven RTS enable |
| cfg_nine_bit | input | 1 | 9-bit characters selected (forces single-character mode) |
| cfg_rdy_gran | input | 2 | Ready granularity code |
| cfg_thr_hi | input | 6 | Upper level threshold |
| cfg_thr_lo | input | 6 | Lower level threshold |
| clr | input | 1 | Queue clear command |
| wr_valid | input | 1 | Character from the receive shifter |
| wr_data | input | 8 | Character value |
| rd_req | input | 1 | Bus read of the holding port (pops on this edge) |
| rd_word | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| rd_data | output | 32 | Read data for the current access |
| level | output | 6 | Stored character count |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| thr_hi_hit | output | 1 | Level at or above upper threshold |
| thr_lo_hit | output | 1 | Level at or below lower threshold |
| ptr_err | output | 1 | Sticky short-read error |
| overrun | output | 1 | Sticky dropped-write error |
| rx_ready | output | 1 | Enough characters for the chosen granularity |
| rts | output | 1 | Request-to-send (1 = stop sending) |

## Verification
The queue is driven in blocks of random write and read probabilities. Write-heavy blocks push the level through the upper threshold into full, which separates overrun handling and RTS assertion from normal storage. Read-heavy blocks drain the level through the lower threshold, which exposes hysteresis errors. Mixed byte and word reads, run with 9-bit mode both on and off, distinguish the four-character pop from the single pop, including short word reads. Directed cases cover a word read with three characters, an exact fill to DEPTH, and clears that coincide with traffic.

// File: rtl/rxq_pkg.sv
// Package: shared types and helpers for the receive queue.
// Assumes characters are 8 bits and the read port is 32 bits wide.
package rxq_pkg;
    localparam int CHAR_W = 8;
    localparam int WORD_W = 32;
    localparam int CHARS_PER_WORD = WORD_W / CHAR_W;

    typedef enum logic [1:0] {
        GRAN_ONE  = 2'd0,
        GRAN_TWO  = 2'd1,
        GRAN_FOUR = 2'd2,
        GRAN_RSVD = 2'd3
    } gran_e;

    // Minimum stored count that raises the ready request for a code.
    function automatic int unsigned gran_min(input gran_e g);
        case (g)
            GRAN_TWO:  return 2;
            GRAN_FOUR: return 4;
            default:   return 1;
        endcase
    endfunction
endpackage

// File: rtl/rxq_ring.sv
// Module: circular character store with level counter.
// Assumes DEPTH is a power of two, at least 8, and below 2**LVL_W.
// The caller never pushes into a full store or pops more than is stored.
module rxq_ring #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [rxq_pkg::CHAR_W-1:0]   din,
    input  logic [2:0]                   pop_cnt,
    output logic [LVL_W-1:0]             level,
    output logic [LVL_W-1:0]             lvl_nxt,
    output logic [rxq_pkg::WORD_W-1:0]   head
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [rxq_pkg::CHAR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]           wp;
    logic [PTR_W-1:0]           rp;

    // Level after this cycle's clear, push and pop.
    always_comb begin
        if (clr) lvl_nxt = '0;
        else     lvl_nxt = level + LVL_W'(push) - LVL_W'(pop_cnt);
    end

    // Character storage write.
    always_ff @(posedge clk) begin
        if (push && !clr) mem[wp] <= din;
    end

    // Pointer and level update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + PTR_W'(push);
            rp    <= rp + PTR_W'(pop_cnt);
            level <= lvl_nxt;
        end
    end

    // Four oldest characters, oldest in the lowest byte.
    for (genvar k = 0; k < rxq_pkg::CHARS_PER_WORD; k++) begin : g_head
        assign head[k*rxq_pkg::CHAR_W +: rxq_pkg::CHAR_W] = mem[rp + PTR_W'(k)];
    end

    // R5
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level < LVL_W'(DEPTH)));

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
endmodule

// File: rtl/rxq_rdsel.sv
// Module: read-access decode. Chooses how many characters an access
// pops, what it returns, and whether it is a short (error) access.
// Assumes head holds the four oldest characters, valid up to level.
module rxq_rdsel #(
    parameter int LVL_W = 6
) (
    input  logic                         mult,
    input  logic                         rd_req,
    input  logic                         rd_word,
    input  logic [LVL_W-1:0]             level,
    input  logic [rxq_pkg::WORD_W-1:0]   head,
    output logic [2:0]                   pop_cnt,
    output logic                         perr_ev,
    output logic [rxq_pkg::WORD_W-1:0]   rd_data
);
    logic four;
    logic avail;

    // Access width, availability, data and pop count.
    always_comb begin
        four  = mult && rd_word;
        avail = four ? (level >= LVL_W'(rxq_pkg::CHARS_PER_WORD)) : (level != '0);
        if (!avail)    rd_data = '0;
        else if (four) rd_data = head;
        else           rd_data = {{(rxq_pkg::WORD_W-rxq_pkg::CHAR_W){1'b0}},
                                  head[rxq_pkg::CHAR_W-1:0]};
        if (rd_req && avail) pop_cnt = four ? 3'd4 : 3'd1;
        else                 pop_cnt = 3'd0;
        perr_ev = rd_req && !avail;
    end
endmodule

// File: rtl/rxq_rts.sv
// Module: request-to-send hysteresis register.
// Assumes 0 < lo < hi; the decision uses the level after this cycle.
module rxq_rts #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             clr,
    input  logic [LVL_W-1:0] lvl_nxt,
    input  logic [LVL_W-1:0] hi,
    input  logic [LVL_W-1:0] lo,
    output logic             rts
);
    // Raise at the upper threshold, drop at the lower one, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || !act || clr) rts <= 1'b0;
        else if (lvl_nxt >= hi)    rts <= 1'b1;
        else if (lvl_nxt <= lo)    rts <= 1'b0;
    end
endmodule

// File: rtl/rxq_flow_top.sv
// Module: receive character queue with level-driven RTS.
// Assumes DEPTH is a power of two between 8 and 63. Configuration
// inputs are static software settings.
module rxq_flow_top #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_fifo_en,
    input  logic        cfg_hs_mode,
    input  logic        cfg_rts_en,
    input  logic        cfg_nine_bit,
    input  logic [1:0]  cfg_rdy_gran,
    input  logic [5:0]  cfg_thr_hi,
    input  logic [5:0]  cfg_thr_lo,
    input  logic        clr,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        rd_req,
    input  logic        rd_word,
    output logic [31:0] rd_data,
    output logic [5:0]  level,
    output logic        empty,
    output logic        full,
    output logic        thr_hi_hit,
    output logic        thr_lo_hit,
    output logic        ptr_err,
    output logic        overrun,
    output logic        rx_ready,
    output logic        rts
);
    import rxq_pkg::*;

    logic [LVL_W-1:0]  lvl_q;
    logic [LVL_W-1:0]  lvl_nxt;
    logic [WORD_W-1:0] head;
    logic [2:0]        pop_cnt;
    logic              perr_ev;
    logic              push;
    logic              mult;
    logic              rts_act;

    // Mode and gating decode.
    always_comb begin
        mult    = cfg_fifo_en && !cfg_nine_bit;
        rts_act = cfg_fifo_en && cfg_hs_mode && cfg_rts_en;
        full    = (lvl_q == LVL_W'(DEPTH));
        push    = wr_valid && !full;
    end

    rxq_ring #(.DEPTH(DEPTH), .LVL_W(LVL_W)) ring_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .din(wr_data),
        .pop_cnt(pop_cnt), .level(lvl_q), .lvl_nxt(lvl_nxt), .head(head)
    );

    rxq_rdsel #(.LVL_W(LVL_W)) rdsel_i (
        .mult(mult), .rd_req(rd_req), .rd_word(rd_word), .level(lvl_q),
        .head(head), .pop_cnt(pop_cnt), .perr_ev(perr_ev), .rd_data(rd_data)
    );

    rxq_rts #(.LVL_W(LVL_W)) rts_i (
        .clk(clk), .rst_n(rst_n), .act(rts_act), .clr(clr), .lvl_nxt(lvl_nxt),
        .hi(cfg_thr_hi), .lo(cfg_thr_lo), .rts(rts)
    );

    // Sticky error flags, cleared by the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr_err <= 1'b0;
            overrun <= 1'b0;
        end else begin
            ptr_err <= ptr_err | perr_ev;
            overrun <= overrun | (wr_valid && full);
        end
    end

    // Live level flags and ready request.
    always_comb begin
        level      = lvl_q;
        empty      = (lvl_q == '0);
        thr_hi_hit = (lvl_q >= cfg_thr_hi);
        thr_lo_hit = (lvl_q <= cfg_thr_lo);
        rx_ready   = (32'(lvl_q) >= gran_min(gran_e'(cfg_rdy_gran)));
    end

    // R3
    short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && mult && rd_word && (lvl_q < 4) && !wr_valid && !clr
        |=> (level == $past(level)) && ptr_err);

    // R5
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && full && !clr && !rd_req |=> overrun && full);

    // R8
    rts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rts_act) && !$past(clr) && ($past(cfg_thr_lo) != 0)
        && ($past(cfg_thr_lo) < $past(cfg_thr_hi)) && (level >= $past(cfg_thr_hi))
        |-> rts);

    // R8
    rts_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_act |=> !rts);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty && !rts && !ptr_err && !overrun);

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({empty, full}));
endmodule

// File: tb/rxq_flow_top_tb_top.sv
module rxq_flow_top_tb_top;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_en = 1'b1, cfg_hs_mode = 1'b1, cfg_rts_en = 1'b1, cfg_nine_bit = 1'b0;
    logic [1:0]  cfg_rdy_gran = 2'd0;
    logic [5:0]  cfg_thr_hi = 6'd12, cfg_thr_lo = 6'd4;
    logic        clr = 1'b0, wr_valid = 1'b0, rd_req = 1'b0, rd_word = 1'b0;
    logic [7:0]  wr_data = 8'd0;
    logic [31:0] rd_data;
    logic [5:0]  level;
    logic        empty, full, thr_hi_hit, thr_lo_hit, ptr_err, overrun, rx_ready, rts;

    always #5 clk = ~clk;

    rxq_flow_top #(.DEPTH(DEPTH), .LVL_W(6)) dut_i (.*);

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    logic [7:0] q[$];
    bit m_rts = 0, m_perr = 0, m_ovr = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic bit f_ready(input int lvl, input logic [1:0] g);
        case (g)
            2'd1:    return lvl >= 2;
            2'd2:    return lvl >= 4;
            default: return lvl >= 1;
        endcase
    endfunction

    // One cycle: drive at negedge, check read data, update model, check state.
    task automatic step(input bit w, input logic [7:0] d, input bit r, input bit wd, input bit c);
        bit mult, four;
        int lvl, nl;
        logic [31:0] exp_d;
        string rtag, stag;
        wr_valid = w; wr_data = d; rd_req = r; rd_word = wd; clr = c;
        #1;
        mult = cfg_fifo_en && !cfg_nine_bit;
        four = mult && wd;
        lvl  = q.size();
        if (four) exp_d = (lvl >= 4) ? {q[3], q[2], q[1], q[0]} : 32'd0;
        else      exp_d = (lvl >= 1) ? {24'd0, q[0]} : 32'd0;
        if (r) begin
            if (four)      rtag = (lvl >= 4) ? "R2" : "R3";
            else if (wd)   rtag = (lvl >= 1) ? "R4" : "R3";
            else           rtag = (lvl >= 1) ? "R1" : "R3";
            chk(rtag, rd_data, exp_d);
        end
        if (c) begin
            q.delete(); m_perr = 0; m_ovr = 0; m_rts = 0;
        end else begin
            if (r) begin
                if (four && lvl >= 4) repeat (4) void'(q.pop_front());
                else if (!four && lvl >= 1) void'(q.pop_front());
                else m_perr = 1;
            end
            if (w) begin
                if (lvl == DEPTH) m_ovr = 1;
                else q.push_back(d);
            end
            nl = q.size();
            if (!(cfg_fifo_en && cfg_hs_mode && cfg_rts_en)) m_rts = 0;
            else if (nl >= cfg_thr_hi) m_rts = 1;
            else if (nl <= cfg_thr_lo) m_rts = 0;
        end
        @(posedge clk);
        #1;
        stag = c ? "R9" : ((w && r) ? "R10" : "R6");
        nl = q.size();
        chk(stag, 32'(level), 32'(nl));
        chk("R6 empty", 32'(empty), 32'(nl == 0));
        chk("R6 full", 32'(full), 32'(nl == DEPTH));
        chk("R6 hi", 32'(thr_hi_hit), 32'(nl >= cfg_thr_hi));
        chk("R6 lo", 32'(thr_lo_hit), 32'(nl <= cfg_thr_lo));
        chk("R7 ready", 32'(rx_ready), 32'(f_ready(nl, cfg_rdy_gran)));
        chk(c ? "R9 rts" : "R8 rts", 32'(rts), 32'(m_rts));
        chk("R3 perr", 32'(ptr_err), 32'(m_perr));
        chk("R5 ovr", 32'(overrun), 32'(m_ovr));
        @(negedge clk);
    endtask

    task automatic rand_block(input int cycles, input int wp, input int rp, input int cp);
        for (int i = 0; i < cycles; i++) begin
            step(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < rp,
                 $urandom % 2, ($urandom % 1000) < cp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R6 reset level", 32'(level), 32'd0);
        chk("R6 reset empty", 32'(empty), 32'd1);
        chk("R8 reset rts", 32'(rts), 32'd0);
        chk("R3 reset perr", 32'(ptr_err), 32'd0);
        @(negedge clk);
        // R3: three stored, word read pops nothing
        for (int i = 0; i < 3; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0);
        step(0, 0, 1, 1, 0);
        // R2: fourth char, word read pops four oldest-first
        step(1, 8'hA3, 0, 0, 0);
        step(0, 0, 1, 1, 0);
        // R3: byte read of empty
        step(0, 0, 1, 0, 0);
        // R9: clear clears errors
        step(1, 8'h55, 1, 0, 1);
        // R5 / R8: fill exactly to DEPTH then overrun
        for (int i = 0; i < DEPTH + 2; i++) step(1, 8'(i * 7), 0, 0, 0);
        // R10: write and read at full
        step(1, 8'hEE, 1, 0, 0);
        // drain through low threshold with byte reads
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1);
        // R8: random hysteresis traffic in multi-character mode
        for (int b = 0; b < 20; b++) rand_block(150, (b % 2) ? 85 : 25, (b % 2) ? 30 : 75, 3);
        // R4: single-character mode through 9-bit selection
        cfg_nine_bit = 1'b1;
        for (int b = 0; b < 6; b++) rand_block(150, (b % 2) ? 80 : 30, (b % 2) ? 35 : 80, 3);
        cfg_nine_bit = 1'b0;
        // R8: control inactive gives rts low
        cfg_rts_en = 1'b0;
        rand_block(400, 70, 40, 2);
        cfg_rts_en = 1'b1;
        cfg_fifo_en = 1'b0;
        rand_block(400, 70, 40, 2);
        cfg_fifo_en = 1'b1;
        // R7: every granularity code, other thresholds
        cfg_thr_hi = 6'd32; cfg_thr_lo = 6'd1;
        for (int g = 0; g < 4; g++) begin
            cfg_rdy_gran = 2'(g);
            rand_block(300, 55, 55, 2);
        end
        step(0, 0, 0, 0, 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule